// File: doc/BRIEF.md
# Tamper Alarm Supervisor Controller

This block watches four physical tamper lines and two supply-fault flags, and drives an active-low security alarm. It also sets the mode of a protected supply output. The over-voltage and under-voltage flags come from external comparators. The lines do not share a resting level: the first and third lines rest high, and the second and fourth rest low. Every line passes through a synchronizer and a hold counter. A line counts as tampered only after its tamper level has been stable for a set number of cycles, and it counts as clear only after the same number of stable cycles at its resting level. The alarm does not latch. It follows the filtered conditions and returns high once every condition has cleared.

Detection is armed only after the main supply has first stayed above its reset threshold for a recovery delay. Once armed, the block stays armed while it runs from the battery. Only a full loss of power clears the armed state, and that loss is modelled by the asynchronous reset. A two-bit variant select chooses what happens to the protected output during an alarm: it stays on, it floats, or it is grounded. A switch-status pin reports whether the output runs from the battery. For the floating and grounded variants, that pin is forced high during an alarm. A per-source vector shows which conditions are currently raising the alarm.

Top module: `tamper_supervisor`

## Requirements
- R1: Lines tamper_pin[0] and tamper_pin[2] signal tamper when low, and tamper_pin[1] and tamper_pin[3] signal tamper when high. Filtered, armed tamper on line i sets fault_src[i].
- R2: Tamper on any single line, once filtered and armed, drives alarm_n low.
- R3: The alarm does not latch. alarm_n returns high once every tamper line and supply flag is back at its resting state and the filters have cleared.
- R4: ovp_flag sets fault_src[4] and uvp_flag sets fault_src[5]. Either one drives alarm_n low SYNC_STAGES cycles after it rises (default 2), and releases it the same number of cycles after it falls.
- R5: A tamper level must be stable for HOLD_CYCLES consecutive synchronized cycles before it is taken. alarm_n falls exactly SYNC_STAGES+HOLD_CYCLES edges after a line changes. A pulse shorter than HOLD_CYCLES cycles has no effect. Clearing a line takes the same number of edges.
- R6: Until main_ok has stayed high for ARM_CYCLES synchronized cycles, alarm_n stays high and fault_src stays zero. The block arms exactly SYNC_STAGES+ARM_CYCLES edges after main_ok rises. A drop of main_ok before that point restarts the count.
- R7: Once armed, the block stays armed when main_ok falls, so detection continues on battery. Only rst_n clears the armed state.
- R8: supply_mode uses the codes 0 = on, 1 = high-Z and 2 = ground. It is 0 whenever alarm_n is high. While the alarm is active it is 0 for variant_sel 0, 1 for variant_sel 1, and 2 for variant_sel 2 or 3.
- R9: switch_stat equals batt_sel when there is no alarm or when variant_sel is 0. While the alarm is active with variant_sel 1, 2 or 3, switch_stat is 1.
- R10: While rst_n is low, alarm_n is 1, supply_mode is 0, fault_src is 0 and switch_stat equals batt_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset (full power loss) |
| tamper_pin | input | 4 | Physical tamper lines, mixed resting levels |
| ovp_flag | input | 1 | Internal supply above over-voltage trip |
| uvp_flag | input | 1 | Internal supply below under-voltage trip |
| main_ok | input | 1 | Main supply above reset threshold |
| batt_sel | input | 1 | Protected output currently fed from battery |
| variant_sel | input | 2 | Alarm action select: 0 on, 1 high-Z, 2/3 ground |
| alarm_n | output | 1 | Security alarm, active low |
| supply_mode | output | 2 | Protected output control: 0 on, 1 high-Z, 2 ground |
| switch_stat | output | 1 | Switch-status indicator |
| fault_src | output | 6 | Active sources: tamper lines [3:0], over-voltage [4], under-voltage [5] |

## Verification
A change on a tamper line reaches alarm_n after exactly SYNC_STAGES+HOLD_CYCLES clock edges. A supply flag reaches it after SYNC_STAGES edges, and arming completes SYNC_STAGES+ARM_CYCLES edges after main_ok rises. supply_mode and switch_stat follow alarm_n in the same cycle. The bench drives every stimulus 1 ns after a rising edge and counts edges from that point. It samples one edge before each due point, where the old value must still hold, and again at the due point, where the new value must appear. The table tests wait past the longest of these latencies before they compare.

// File: rtl/tamper_sup_pkg.sv
package tamper_sup_pkg;

   localparam int NUM_TAMPER = 4;
   localparam int NUM_SRC    = NUM_TAMPER + 2;

   typedef enum logic [1:0] {
      SUP_ON  = 2'd0,
      SUP_HIZ = 2'd1,
      SUP_GND = 2'd2
   } sup_mode_e;

   typedef enum logic [1:0] {
      VAR_KEEP  = 2'd0,
      VAR_FLOAT = 2'd1,
      VAR_SINK  = 2'd2,
      VAR_SINK2 = 2'd3
   } variant_e;

endpackage

// File: rtl/tsup_sync.sv
module tsup_sync #(
   parameter int WIDTH  = 7,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tsup_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("tsup_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/tsup_glitch_filter.sv
module tsup_glitch_filter #(
   parameter int HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic hit
);

   localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

   generate
      if (HOLD < 2) begin : g_bad_hold
         $error("tsup_glitch_filter: HOLD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          hit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         hit_q <= 1'b0;
      end else if (level != hit_q) begin
         if (cnt == LAST) begin
            hit_q <= level;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         cnt <= '0;
      end
   end

   assign hit = hit_q;

endmodule

// File: rtl/tsup_arm_timer.sv
module tsup_arm_timer #(
   parameter int DELAY = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   output logic armed
);

   localparam int CW = (DELAY > 2) ? $clog2(DELAY) : 1;
   localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

   generate
      if (DELAY < 2) begin : g_bad_delay
         $error("tsup_arm_timer: DELAY must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         armed_q <= 1'b0;
      end else if (!armed_q) begin
         if (!supply_ok) begin
            cnt <= '0;
         end else if (cnt == LAST) begin
            armed_q <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign armed = armed_q;

endmodule

// File: rtl/tsup_action.sv
module tsup_action
   import tamper_sup_pkg::*;
(
   input  logic      alarm,
   input  logic [1:0] variant,
   input  logic      on_batt,
   output sup_mode_e mode,
   output logic      status
);

   always_comb begin
      mode   = SUP_ON;
      status = on_batt;
      if (alarm) begin
         unique case (variant_e'(variant))
            VAR_KEEP: begin
               mode   = SUP_ON;
               status = on_batt;
            end
            VAR_FLOAT: begin
               mode   = SUP_HIZ;
               status = 1'b1;
            end
            VAR_SINK, VAR_SINK2: begin
               mode   = SUP_GND;
               status = 1'b1;
            end
            default: begin
               mode   = SUP_GND;
               status = 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/tamper_supervisor.sv
module tamper_supervisor
   import tamper_sup_pkg::*;
#(
   parameter int        HOLD_CYCLES    = 16,
   parameter int        ARM_CYCLES     = 4096,
   parameter int        SYNC_STAGES    = 2,
   parameter logic [3:0] IDLE_HIGH_MASK = 4'b0101
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] tamper_pin,
   input  logic       ovp_flag,
   input  logic       uvp_flag,
   input  logic       main_ok,
   input  logic       batt_sel,
   input  logic [1:0] variant_sel,
   output logic       alarm_n,
   output logic [1:0] supply_mode,
   output logic       switch_stat,
   output logic [5:0] fault_src
);

   localparam int NSYNC  = NUM_TAMPER + 3;
   localparam int OV_IDX = NUM_TAMPER;
   localparam int UV_IDX = NUM_TAMPER + 1;
   localparam int MO_IDX = NUM_TAMPER + 2;

   generate
      if (NUM_SRC != 6) begin : g_bad_src
         $error("tamper_supervisor: source vector width mismatch");
      end
   endgenerate

   logic [NUM_TAMPER-1:0] tamp_raw;
   logic [NUM_TAMPER-1:0] tamp_sync;
   logic [NUM_TAMPER-1:0] tamp_hit;
   logic [NSYNC-1:0]      sync_in;
   logic [NSYNC-1:0]      sync_out;
   logic                  ov_s;
   logic                  uv_s;
   logic                  main_s;
   logic                  armed_w;
   logic                  alarm_act;
   sup_mode_e             mode_w;

   // normalise so that 1 always means "tamper level"
   assign tamp_raw = tamper_pin ^ IDLE_HIGH_MASK;
   assign sync_in  = {main_ok, uvp_flag, ovp_flag, tamp_raw};

   tsup_sync #(
      .WIDTH (NSYNC),
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (sync_in),
      .q    (sync_out)
   );

   assign tamp_sync = sync_out[NUM_TAMPER-1:0];
   assign ov_s      = sync_out[OV_IDX];
   assign uv_s      = sync_out[UV_IDX];
   assign main_s    = sync_out[MO_IDX];

   generate
      for (genvar i = 0; i < NUM_TAMPER; i++) begin : g_filt
         tsup_glitch_filter #(
            .HOLD(HOLD_CYCLES)
         ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .level(tamp_sync[i]),
            .hit  (tamp_hit[i])
         );
      end
   endgenerate

   tsup_arm_timer #(
      .DELAY(ARM_CYCLES)
   ) u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .supply_ok(main_s),
      .armed    (armed_w)
   );

   assign fault_src = armed_w ? {uv_s, ov_s, tamp_hit} : '0;
   assign alarm_act = |fault_src;
   assign alarm_n   = ~alarm_act;

   tsup_action u_act (
      .alarm  (alarm_act),
      .variant(variant_sel),
      .on_batt(batt_sel),
      .mode   (mode_w),
      .status (switch_stat)
   );

   assign supply_mode = mode_w;

endmodule

// File: rtl/tamper_supervisor_chk.sv
module tamper_supervisor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       alarm_n,
   input logic [1:0] supply_mode,
   input logic       switch_stat,
   input logic [1:0] variant_sel,
   input logic [5:0] fault_src,
   input logic       armed,
   input logic [3:0] filt_in,
   input logic [3:0] filt_state
);

   assert_quiet_disarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !armed |-> (alarm_n && fault_src == 6'd0));

   assert_armed_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed);

   assert_mode_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_n |-> supply_mode == 2'd0);

   assert_mode_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_n && variant_sel == 2'd1) |-> supply_mode == 2'd1);

   assert_sw_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!alarm_n && variant_sel != 2'd0) |-> switch_stat);

   generate
      for (genvar i = 0; i < 4; i++) begin : g_line
         assert_filter_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(filt_state[i]) |-> $past(filt_in[i]));
         assert_filter_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(filt_state[i]) |-> !$past(filt_in[i]));
      end
   endgenerate

endmodule

bind tamper_supervisor tamper_supervisor_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .alarm_n    (alarm_n),
   .supply_mode(supply_mode),
   .switch_stat(switch_stat),
   .variant_sel(variant_sel),
   .fault_src  (fault_src),
   .armed      (armed_w),
   .filt_in    (tamp_sync),
   .filt_state (tamp_hit)
);

// File: tb/sim_tamper_supervisor.sv
`timescale 1ns/1ps
module sim_tamper_supervisor;

   localparam int HOLD = 8;
   localparam int ARM  = 40;
   localparam int SYNC = 2;
   localparam int SETTLE = SYNC + HOLD + 2;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] tamper_pin;
   logic       ovp_flag, uvp_flag, main_ok, batt_sel;
   logic [1:0] variant_sel;
   logic       alarm_n;
   logic [1:0] supply_mode;
   logic       switch_stat;
   logic [5:0] fault_src;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   tamper_supervisor #(
      .HOLD_CYCLES(HOLD),
      .ARM_CYCLES (ARM),
      .SYNC_STAGES(SYNC)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .tamper_pin(tamper_pin),
      .ovp_flag(ovp_flag), .uvp_flag(uvp_flag), .main_ok(main_ok),
      .batt_sel(batt_sel), .variant_sel(variant_sel),
      .alarm_n(alarm_n), .supply_mode(supply_mode),
      .switch_stat(switch_stat), .fault_src(fault_src)
   );

   // {tamper_pin, ov, uv, variant, batt, exp_alarm_n, exp_mode, exp_sw, exp_src}
   localparam logic [18:0] VEC [10] = '{
      {4'b0101, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 6'b000000},
      {4'b0100, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 6'b000001},
      {4'b0111, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 2'd1, 1'b1, 6'b000010},
      {4'b0001, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 2'd2, 1'b1, 6'b000100},
      {4'b1101, 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 2'd2, 1'b1, 6'b001000},
      {4'b0101, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 2'd1, 1'b1, 6'b010000},
      {4'b0101, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 2'd0, 1'b1, 6'b100000},
      {4'b0101, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 2'd0, 1'b1, 6'b000000},
      {4'b1010, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 2'd2, 1'b1, 6'b111111},
      {4'b0101, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 2'd0, 1'b0, 6'b000000}
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; tamper_pin = 4'b0101; ovp_flag = 0; uvp_flag = 0;
      main_ok = 0; batt_sel = 1; variant_sel = 2'd2;
      tick(3);
      // R10 reset state
      chk("R10", "reset alarm_n", alarm_n, 1);
      chk("R10", "reset supply_mode", supply_mode, 0);
      chk("R10", "reset fault_src", fault_src, 0);
      chk("R10", "reset switch_stat", switch_stat, 1);
      rst_n = 1'b1;

      // R6: tamper present but not armed
      tamper_pin = 4'b0100;
      tick(SETTLE + 2);
      chk("R6", "disarmed alarm_n", alarm_n, 1);
      chk("R6", "disarmed fault_src", fault_src, 0);
      main_ok = 1; tick(10);
      main_ok = 0; tick(5);
      main_ok = 1;
      tick(SYNC + ARM - 1);
      chk("R6", "restarted count not done", alarm_n, 1);
      tick(1);
      chk("R6", "armed at due edge", alarm_n, 0);
      chk("R1", "line0 low source", fault_src, 6'b000001);

      // R7: armed persists on battery
      main_ok = 0; batt_sel = 1;
      tick(ARM + 10);
      chk("R7", "alarm on battery", alarm_n, 0);
      chk("R8", "ground mode", supply_mode, 2);
      chk("R9", "switch forced", switch_stat, 1);

      // R3/R5: clear timing
      tamper_pin = 4'b0101;
      tick(SYNC + HOLD - 1);
      chk("R5", "clear not yet", alarm_n, 0);
      tick(1);
      chk("R3", "alarm released", alarm_n, 1);

      // table walk: R1 R2 R4 R8 R9 R3
      for (int k = 0; k < 10; k++) begin
         logic [18:0] v;
         v = VEC[k];
         tamper_pin = v[18:15]; ovp_flag = v[14]; uvp_flag = v[13];
         variant_sel = v[12:11]; batt_sel = v[10];
         tick(SETTLE);
         chk("R2", $sformatf("vec%0d alarm_n", k), alarm_n, v[9]);
         chk("R8", $sformatf("vec%0d supply_mode", k), supply_mode, v[8:7]);
         chk("R9", $sformatf("vec%0d switch_stat", k), switch_stat, v[6]);
         chk("R1", $sformatf("vec%0d fault_src", k), fault_src, v[5:0]);
      end

      // R5: short pulse ignored
      variant_sel = 2'd0; batt_sel = 0;
      tamper_pin = 4'b1101;
      tick(HOLD - 1);
      tamper_pin = 4'b0101;
      begin
         int seen;
         seen = 0;
         for (int c = 0; c < SETTLE + 4; c++) begin
            tick(1);
            if (alarm_n == 1'b0) seen = 1;
         end
         chk("R5", "short pulse", seen, 0);
      end

      // R5: exact set edge
      tamper_pin = 4'b1101;
      tick(SYNC + HOLD - 1);
      chk("R5", "set not yet", alarm_n, 1);
      tick(1);
      chk("R5", "set at due edge", alarm_n, 0);
      chk("R1", "line3 high source", fault_src, 6'b001000);
      chk("R8", "variant0 keeps on", supply_mode, 0);
      chk("R9", "variant0 follows batt", switch_stat, 0);
      tamper_pin = 4'b0101;
      tick(SETTLE);
      chk("R3", "released after line3", alarm_n, 1);

      // R4: over-voltage latency
      ovp_flag = 1;
      tick(SYNC - 1);
      chk("R4", "ov not yet", alarm_n, 1);
      tick(1);
      chk("R4", "ov alarm", alarm_n, 0);
      ovp_flag = 0;
      tick(SYNC);
      chk("R4", "ov released", alarm_n, 1);

      // R7: only reset clears arming
      tamper_pin = 4'b0100;
      tick(SETTLE);
      chk("R2", "armed tamper", alarm_n, 0);
      rst_n = 0; #1;
      chk("R10", "async reset alarm_n", alarm_n, 1);
      chk("R10", "async reset fault_src", fault_src, 0);
      tick(2);
      rst_n = 1;
      tick(SYNC + ARM + 10);
      chk("R7", "disarmed after reset", alarm_n, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule